// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Code Register Front End

This block is the digital front end of a two-channel voltage-output converter. A host writes a parallel code word, together with one address bit that picks channel A or channel B, by pulling an active-low chip select low. The word lands in that channel's staging register only. Each channel then has its own active-low load strobe, which moves the staged word into the converter-facing code register. The two strobes may be pulsed together, so that both outputs move in the same cycle after the staging registers were filled one at a time. They may also be pulsed separately, so that one channel updates alone.

An asynchronous active-low reset clears every register to zero-scale at once, without a clock edge. An active-low shutdown input removes the drive enable of both output buffers. Writes and loads continue to work while shutdown is held, so the codes shown after shutdown is released are the latest loaded ones. The code width is a parameter, 12 or 10 bits, and the port list is the same for both widths. All control inputs are brought into the single clock domain through synchronizers, and the strobes act on their falling edges.

Top module: `dual_dac_regif`

## Requirements
- R1: After reset, code_a and code_b read zero. Both staging registers also hold zero, so a load pulse right after reset leaves both codes at zero.
- R2: A falling edge of cs_n writes wr_data into the staging register of the channel chosen by chan_sel (0 selects A, 1 selects B). The codes stay unchanged until a load.
- R3: A falling edge of load_a_n copies only staging register A into code_a, and a falling edge of load_b_n copies only staging register B into code_b. The other channel keeps its code.
- R4: When load_a_n and load_b_n fall in the same cycle, code_a and code_b both update on the same clock edge.
- R5: Driving rst_n low forces code_a and code_b to zero at once, with no clock edge needed.
- R6: While shdn_n is low, drive_en_a and drive_en_b are low. Two clock edges after shdn_n goes high (outside reset), both are high.
- R7: Writes and loads made while shdn_n is low take effect. After shdn_n is released, the codes show the most recent loaded values.
- R8: When a write and a load for the same channel take effect in the same cycle, that code takes the staging value from before the write. The new word waits for the next load.
- R9: A strobe held low acts once. A change of wr_data or chan_sel while cs_n stays low writes nothing.
- R10: Writes and loads pulsed while rst_n is low have no effect. Once rst_n is released, every register still reads zero.
- R11: A strobe edge shows on the codes within three clock edges of the strobe input falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_data | input | DATA_W | Parallel code word from the host |
| chan_sel | input | 1 | Write address: 0 = channel A, 1 = channel B |
| cs_n | input | 1 | Active-low write strobe, acts on its falling edge |
| load_a_n | input | 1 | Active-low load strobe for channel A |
| load_b_n | input | 1 | Active-low load strobe for channel B |
| shdn_n | input | 1 | Active-low shutdown of both output buffers |
| code_a | output | DATA_W | Converter code of channel A |
| code_b | output | DATA_W | Converter code of channel B |
| drive_en_a | output | 1 | Output buffer drive enable, channel A |
| drive_en_b | output | 1 | Output buffer drive enable, channel B |

## Verification
The bench goes after a write and a load to the same channel landing in the same cycle. A design that forwards the fresh word would show it early on the code. It also checks that a strobe held low while the data bus changes acts only once, where a level-sensitive design would keep rewriting the staging register. Other directed cases drop rst_n between clock edges and pulse strobes during reset: a design with only a synchronous clear would keep stale codes, and one that leaves the staging registers alone would bring old data back on the first load. Writes and loads made under shutdown must still show after release, which catches a design that gates its registers with shutdown.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic {
    CH_A = 1'b0,
    CH_B = 1'b1
  } chan_e;

  // strobe bit positions inside the synchronizer bundle
  localparam int unsigned STB_CS  = 0;
  localparam int unsigned STB_LDA = 1;
  localparam int unsigned STB_LDB = 2;
  localparam int unsigned STB_SHD = 3;
  localparam int unsigned STB_W   = 4;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/dac_strobe_sync.sv
module dac_strobe_sync #(
  parameter int unsigned     WIDTH   = 4,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [STAGES-1:0][WIDTH-1:0] sync_q;
  logic [STAGES-1:0][WIDTH-1:0] sync_d;
  logic [WIDTH-1:0]             last_q;
  logic [WIDTH-1:0]             last_d;

  always_comb begin
    sync_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      sync_d[s] = sync_q[s-1];
    end
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int s = 0; s < STAGES; s++) begin
        sync_q[s] <= RST_VAL;
      end
      last_q <= RST_VAL;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              ld_en,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] code_q
);
  logic [DATA_W-1:0] stage_d;
  logic [DATA_W-1:0] code_d;

  always_comb begin
    stage_d = stage_q;
    code_d  = code_q;
    if (wr_en) begin
      stage_d = wr_word;
    end
    if (ld_en) begin
      code_d = stage_q;  // pre-write value on a same-cycle collision
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      stage_q <= '0;
      code_q  <= '0;
    end else begin
      stage_q <= stage_d;
      code_q  <= code_d;
    end
  end
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
  import dac_regif_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              chan_sel,
  input  logic              cs_n,
  input  logic              load_a_n,
  input  logic              load_b_n,
  input  logic              shdn_n,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              drive_en_a,
  output logic              drive_en_b
);
  localparam logic [STB_W-1:0] STB_IDLE = STB_W'(4'b0111);

  logic                           rst_q_n;
  logic [STB_W-1:0]               stb_raw;
  logic [STB_W-1:0]               stb_lvl;
  logic [STB_W-1:0]               stb_fall;
  logic                           wr_pls;
  logic [NUM_CH-1:0]              ld_pls;
  logic [NUM_CH-1:0]              wr_en;
  logic [NUM_CH-1:0][DATA_W-1:0]  in_q;
  logic [NUM_CH-1:0][DATA_W-1:0]  dac_q;

  dac_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    stb_raw          = '0;
    stb_raw[STB_CS]  = cs_n;
    stb_raw[STB_LDA] = load_a_n;
    stb_raw[STB_LDB] = load_b_n;
    stb_raw[STB_SHD] = shdn_n;
  end

  dac_strobe_sync #(
    .WIDTH   (STB_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (STB_IDLE)
  ) stb_sync_i (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .async_i (stb_raw),
    .level_o (stb_lvl),
    .fall_o  (stb_fall)
  );

  assign wr_pls            = stb_fall[STB_CS];
  assign ld_pls[int'(CH_A)] = stb_fall[STB_LDA];
  assign ld_pls[int'(CH_B)] = stb_fall[STB_LDB];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign wr_en[c] = wr_pls && (chan_sel == c[0]);

    dac_chan_regs #(.DATA_W(DATA_W)) regs_i (
      .clk     (clk),
      .rst_q_n (rst_q_n),
      .wr_en   (wr_en[c]),
      .wr_word (wr_data),
      .ld_en   (ld_pls[c]),
      .stage_q (in_q[c]),
      .code_q  (dac_q[c])
    );
  end

  assign code_a     = dac_q[int'(CH_A)];
  assign code_b     = dac_q[int'(CH_B)];
  assign drive_en_a = stb_lvl[STB_SHD];
  assign drive_en_b = stb_lvl[STB_SHD];
endmodule

// File: rtl/dual_dac_regif_chk.sv
module dual_dac_regif_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rst_q_n,
  input logic                    shdn_n,
  input logic                    chan_sel,
  input logic                    wr_pls,
  input logic [1:0]              ld_pls,
  input logic [1:0][DATA_W-1:0]  in_q,
  input logic [DATA_W-1:0]       code_a,
  input logic [DATA_W-1:0]       code_b,
  input logic                    drive_en_a,
  input logic                    drive_en_b
);
  // R10: while the internal reset holds, codes are cleared
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q_n |=> (code_a == '0 && code_b == '0));

  // R6: a buffer is only enabled if shutdown was released two edges back
  a_r6_shdn_gates_a: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_a |-> $past(shdn_n, 2));
  a_r6_shdn_gates_b: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en_b |-> $past(shdn_n, 2));

  // R3: a code only moves after its own load pulse
  a_r3_code_a_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_a) |-> $past(ld_pls[0]));
  a_r3_code_b_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_b) |-> $past(ld_pls[1]));

  // R4: a joint load moves both staged words together
  a_r4_joint_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_pls == 2'b11) |=> (code_a == $past(in_q[0]) && code_b == $past(in_q[1])));

  // R8: collision of write and load keeps the old staged word
  a_r8_collision_a: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pls && !chan_sel && ld_pls[0]) |=> code_a == $past(in_q[0]));
  a_r8_collision_b: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pls && chan_sel && ld_pls[1]) |=> code_b == $past(in_q[1]));
endmodule

bind dual_dac_regif dual_dac_regif_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_q_n    (rst_q_n),
  .shdn_n     (shdn_n),
  .chan_sel   (chan_sel),
  .wr_pls     (wr_pls),
  .ld_pls     (ld_pls),
  .in_q       (in_q),
  .code_a     (code_a),
  .code_b     (code_b),
  .drive_en_a (drive_en_a),
  .drive_en_b (drive_en_b)
);

// File: tb/dual_dac_regif_tb_top.sv
module dual_dac_regif_tb_top;
  localparam int unsigned DW = 12;
  localparam logic [31:0] DMASK = (32'd1 << DW) - 32'd1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] wr_data;
  logic          chan_sel;
  logic          cs_n;
  logic          load_a_n;
  logic          load_b_n;
  logic          shdn_n;
  logic [DW-1:0] code_a;
  logic [DW-1:0] code_b;
  logic          drive_en_a;
  logic          drive_en_b;

  int checks   = 0;
  int failures = 0;
  logic [31:0] exp_in [2];
  logic [31:0] exp_dac [2];
  bit exp_en;

  always #4 clk = ~clk;  // 125 MHz

  dual_dac_regif #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .chan_sel(chan_sel),
    .cs_n(cs_n), .load_a_n(load_a_n), .load_b_n(load_b_n), .shdn_n(shdn_n),
    .code_a(code_a), .code_b(code_b),
    .drive_en_a(drive_en_a), .drive_en_b(drive_en_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " code_a"}, 32'(code_a), exp_dac[0]);
    check({req, " code_b"}, 32'(code_b), exp_dac[1]);
    check({req, " drive_en_a"}, 32'(drive_en_a), 32'(exp_en));
    check({req, " drive_en_b"}, 32'(drive_en_b), 32'(exp_en));
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] pick_load(input logic [1:0] m, input int c);
    return m[c] ? exp_in[c] : exp_dac[c];
  endfunction

  // write and optional loads whose strobes fall in the same cycle
  task automatic op(input bit do_wr, input logic ch, input logic [31:0] val,
                    input logic [1:0] ldm);
    @(negedge clk);
    chan_sel = ch;
    wr_data  = val[DW-1:0];
    if (do_wr) cs_n = 1'b0;
    load_a_n = ~ldm[0];
    load_b_n = ~ldm[1];
    cycles(4);
    cs_n = 1'b1; load_a_n = 1'b1; load_b_n = 1'b1;
    cycles(3);
    for (int c = 0; c < 2; c++) exp_dac[c] = pick_load(ldm, c);
    if (do_wr) exp_in[int'(ch)] = val & DMASK;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    for (int c = 0; c < 2; c++) begin exp_in[c] = 0; exp_dac[c] = 0; end
  endtask

  task automatic set_shdn(input bit v);
    @(negedge clk);
    shdn_n = v;
    cycles(3);
    exp_en = v;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'h5EED_0042);
    rst_n = 1'b0; wr_data = '0; chan_sel = 1'b0; cs_n = 1'b1;
    load_a_n = 1'b1; load_b_n = 1'b1; shdn_n = 1'b1; exp_en = 1'b1;
    for (int c = 0; c < 2; c++) begin exp_in[c] = 0; exp_dac[c] = 0; end
    cycles(3);
    rst_n = 1'b1;
    cycles(5);

    // R1: reset state, then load both: staging was zero
    check_all("R1 reset");
    op(1'b0, 1'b0, 0, 2'b11);
    check_all("R1 load after reset");

    // R2: writes reach only staging
    op(1'b1, 1'b0, 32'h5A3, 2'b00);
    op(1'b1, 1'b1, 32'hC3C, 2'b00);
    check_all("R2 write no output change");

    // R3: load A alone, then B alone
    op(1'b0, 1'b0, 0, 2'b01);
    check_all("R3 load A only");
    op(1'b0, 1'b0, 0, 2'b10);
    check_all("R3 load B only");

    // R4: stage both then joint load
    op(1'b1, 1'b0, 32'h123, 2'b00);
    op(1'b1, 1'b1, 32'hFED, 2'b00);
    op(1'b0, 1'b0, 0, 2'b11);
    check_all("R4 joint load");

    // R11: latency - code valid three edges after the strobe falls
    op(1'b1, 1'b0, 32'h7E7, 2'b00);
    @(negedge clk);
    load_a_n = 1'b0;
    cycles(3);
    check("R11 code_a after three edges", 32'(code_a), 32'h7E7);
    cycles(1);
    load_a_n = 1'b1;
    cycles(3);
    exp_dac[0] = 32'h7E7;

    // R8: collision on A and on B
    op(1'b1, 1'b0, 32'h0AA, 2'b01);
    check_all("R8 collision A keeps old");
    op(1'b0, 1'b0, 0, 2'b01);
    check_all("R8 new word on next load");
    op(1'b1, 1'b1, 32'h555, 2'b10);
    check_all("R8 collision B keeps old");

    // R9: bus change while cs_n held low is ignored
    @(negedge clk);
    chan_sel = 1'b1; wr_data = 12'h31F; cs_n = 1'b0;
    cycles(4);
    wr_data = 12'hBAD; chan_sel = 1'b0;
    cycles(4);
    cs_n = 1'b1;
    cycles(3);
    exp_in[1] = 32'h31F;
    op(1'b0, 1'b0, 0, 2'b11);
    check_all("R9 held strobe acts once");

    // R6 + R7: shutdown gates enables, registers still work
    set_shdn(1'b0);
    check_all("R6 shutdown enables low");
    op(1'b1, 1'b0, 32'h246, 2'b00);
    op(1'b1, 1'b1, 32'h9BD, 2'b11);
    op(1'b0, 1'b0, 0, 2'b11);
    check_all("R7 writes under shutdown");
    set_shdn(1'b1);
    check_all("R7 release shows latest");

    // R5: asynchronous reset between clock edges
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R5 async code_a", 32'(code_a), 0);
    check("R5 async code_b", 32'(code_b), 0);
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    for (int c = 0; c < 2; c++) begin exp_in[c] = 0; exp_dac[c] = 0; end
    op(1'b0, 1'b0, 0, 2'b11);
    check_all("R5 staging cleared");

    // R10: strobes during reset ignored
    op(1'b1, 1'b0, 32'h111, 2'b00);
    op(1'b0, 1'b0, 0, 2'b01);
    @(negedge clk);
    rst_n = 1'b0;
    chan_sel = 1'b1; wr_data = 12'hABC; cs_n = 1'b0; load_a_n = 1'b0; load_b_n = 1'b0;
    cycles(4);
    cs_n = 1'b1; load_a_n = 1'b1; load_b_n = 1'b1;
    cycles(2);
    rst_n = 1'b1;
    cycles(4);
    for (int c = 0; c < 2; c++) begin exp_in[c] = 0; exp_dac[c] = 0; end
    check_all("R10 strobes in reset");
    op(1'b0, 1'b0, 0, 2'b11);
    check_all("R10 load after reset zero");

    // random mix against the model
    for (int k = 0; k < 200; k++) begin
      int unsigned r;
      r = $urandom % 5;
      case (r)
        0: op(1'b1, 1'($urandom), $urandom, 2'b00);
        1: op(1'b0, 1'b0, 0, 2'($urandom % 3 + 1));
        2: set_shdn(1'($urandom));
        3: op(1'b1, 1'($urandom), $urandom, 2'($urandom));
        default: if (($urandom % 8) == 0) do_reset();
      endcase
      check_all("R2 R3 R7 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule